// File: doc/BRIEF.md
# Sampled-Trigger Watchdog Supervisor

This block supervises a microcontroller by watching a single trigger line that the software is expected to toggle regularly. Each time the supply-side reset is released, the block first runs an ignore window during which trigger activity is disregarded. It then runs supervision periods back to back. A qualified trigger inside a period starts a new period. If a period ends with no qualified trigger, the block raises a one-cycle reset request and then waits for the next reset release.

The trigger line is sampled on a slow strobe that is derived from the system clock by an internal prescaler. A trigger counts only when four successive samples read high, high, low, low, which rejects short glitches. Two strap bits select fast timing, slow timing or no supervision. A new selection is adopted only at a period boundary. Two load-current comparator flags suspend supervision at light load and resume it at heavier load, with hysteresis between the two thresholds.

Top module: `wdg_supervisor`

## Requirements
- R1: After `rst_n` is asserted and while `rel_i` is low, `rst_req_o` stays 0.
- R2: With mode bits {`mode_b1_i`,`mode_b0_i`} = 00 (fast: one sample every CLKS_PER_TICK clocks), and no triggers, the request rises exactly 2·PERIOD_SAMPLES·CLKS_PER_TICK+1 clock edges after `rel_i` is first seen high. The count includes that first edge. The time consists of one ignore window and one period, each PERIOD_SAMPLES samples long.
- R3: Mode bits 01 select slow timing (one sample every SLOW_DIV·CLKS_PER_TICK clocks). The ignore window and the period then each take twice as long, and the request rises at 2·PERIOD_SAMPLES·SLOW_DIV·CLKS_PER_TICK+1 edges.
- R4: Mode bits 10 also select fast timing, with the same request time as in R2.
- R5: Mode bits 11 switch supervision off, and `rst_req_o` is never raised.
- R6: The mode bits are read at reset release and again at each period boundary: the end of the ignore window, a restart by a trigger, or an unrequested rollover. A change made during the ignore window first affects the period that follows it.
- R7: Qualified triggers that complete during the ignore window have no effect on when the request is raised.
- R8: A qualified trigger during supervision restarts the period, which delays the request by a full period from the trigger.
- R9: A trigger qualifies only when four consecutive samples read 1,1,0,0, oldest first. A single low sample between highs, or a single high sample between lows, does not qualify.
- R10: A pulse on `load_lo_i` suspends supervision, and no request is raised while suspended. Only a pulse on `load_hi_i` resumes it, and a fresh full period then starts.
- R11: The request lasts exactly one cycle. Afterwards no further request is raised until `rel_i` has gone low and high again. Dropping `rel_i` mid-run cancels supervision, and the next release restarts with the ignore window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rel_i | input | 1 | Supply reset released (1 = released) |
| trig_i | input | 1 | Trigger line from the microcontroller (asynchronous) |
| mode_b1_i | input | 1 | Mode strap bit 1 (upper bit of the mode code) |
| mode_b0_i | input | 1 | Mode strap bit 0 (lower bit of the mode code) |
| load_lo_i | input | 1 | Load current below the deactivation threshold |
| load_hi_i | input | 1 | Load current above the activation threshold |
| rst_req_o | output | 1 | One-cycle reset request on a missed trigger |

## Verification
The bench measures the request time to the exact clock edge in both fast encodings and in slow mode. A design whose ignore window were missing, or were the wrong length, would therefore miss the expected count. A mode change made during the ignore window must give a distinct count: a design that adopted the change at once would stretch the ignore window, and one that never adopted it would keep fast timing. The bench also drives trigger pulses inside the ignore window, and glitch patterns with only one low or one high sample. A weaker pattern decoder would restart the period early and push the request past the expected edge. Finally, the bench suspends supervision past the expiry point, checks that nothing is requested after a completed request, and cancels a run by dropping the release. These catch a missing hysteresis latch, a request that repeats, and a sequencer that resumes instead of restarting.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [1:0] {
      MODE_FAST = 2'd0,
      MODE_SLOW = 2'd1,
      MODE_OFF  = 2'd2
   } wd_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_IGNORE = 2'd1,
      ST_WATCH  = 2'd2,
      ST_DONE   = 2'd3
   } wd_state_e;

   // strap code {b1,b0}: 00 fast, 01 slow, 10 fast, 11 off
   function automatic wd_mode_e decode_mode(input logic b1, input logic b0);
      wd_mode_e m;
      case ({b1, b0})
         2'b01:   m = MODE_SLOW;
         2'b11:   m = MODE_OFF;
         default: m = MODE_FAST;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase
   import wdg_pkg::*;
#(
   parameter int CLKS_PER_TICK = 4,
   parameter int SLOW_DIV      = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  wd_mode_e mode_i,
   output logic     strobe_o
);

   localparam int TW      = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
   localparam int DW      = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
   localparam logic [TW-1:0] TICK_LAST = TW'(CLKS_PER_TICK - 1);
   localparam logic [DW-1:0] DIV_LAST  = DW'(SLOW_DIV - 1);

   generate
      if (CLKS_PER_TICK < 2) begin : g_bad_tick
         $error("wdg_timebase: CLKS_PER_TICK must be at least 2");
      end
      if (SLOW_DIV < 1) begin : g_bad_div
         $error("wdg_timebase: SLOW_DIV must be at least 1");
      end
   endgenerate

   logic [TW-1:0] tick_cnt;
   logic          tick;

   assign tick = (tick_cnt == TICK_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (clr_i || tick) begin
         tick_cnt <= '0;
      end else begin
         tick_cnt <= tick_cnt + 1'b1;
      end
   end

   logic slow_hit;

   generate
      if (SLOW_DIV > 1) begin : g_div
         logic [DW-1:0] div_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (clr_i) begin
               div_cnt <= '0;
            end else if (tick) begin
               div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
            end
         end
         assign slow_hit = tick && (div_cnt == DIV_LAST);
      end else begin : g_nodiv
         assign slow_hit = tick;
      end
   endgenerate

   always_comb begin
      if (clr_i) begin
         strobe_o = 1'b0;
      end else if (mode_i == MODE_SLOW) begin
         strobe_o = slow_hit;
      end else begin
         strobe_o = tick;
      end
   end

   // R3
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);

endmodule

// File: rtl/wdg_trig_qual.sv
module wdg_trig_qual #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic strobe_i,
   input  logic trig_i,
   output logic valid_o
);

   localparam int HIST_LEN = 4;
   localparam logic [HIST_LEN-1:0] PATTERN = 4'b1100;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("wdg_trig_qual: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic trig_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign trig_s = trig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], trig_i};
            end
         end
         assign trig_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [HIST_LEN-1:0] hist_q;
   logic [HIST_LEN-1:0] hist_d;

   assign hist_d = {hist_q[HIST_LEN-2:0], trig_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q  <= '0;
         valid_o <= 1'b0;
      end else if (clr_i) begin
         hist_q  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= strobe_i && (hist_d == PATTERN);
         if (strobe_i) begin
            hist_q <= hist_d;
         end
      end
   end

   // R9
   valid_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(strobe_i));

   // R9
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

endmodule

// File: rtl/wdg_load_gate.sv
module wdg_load_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic load_lo_i,
   input  logic load_hi_i,
   output logic en_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o <= 1'b1;
      end else if (load_hi_i) begin
         en_o <= 1'b1;
      end else if (load_lo_i) begin
         en_o <= 1'b0;
      end
   end

   // R10
   resume_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> $past(load_hi_i));

   // R10
   suspend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o) |-> $past(load_lo_i));

endmodule

// File: rtl/wdg_seq.sv
module wdg_seq
   import wdg_pkg::*;
#(
   parameter int PERIOD_SAMPLES = 64
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rel_i,
   input  logic     strobe_i,
   input  logic     trig_valid_i,
   input  logic     load_en_i,
   input  wd_mode_e mode_req_i,
   output logic     clr_o,
   output wd_mode_e act_mode_o,
   output logic     req_o
);

   localparam int CW = (PERIOD_SAMPLES > 1) ? $clog2(PERIOD_SAMPLES) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD_SAMPLES - 1);

   generate
      if (PERIOD_SAMPLES < 2) begin : g_bad_period
         $error("wdg_seq: PERIOD_SAMPLES must be at least 2");
      end
   endgenerate

   wd_state_e     state;
   logic [CW-1:0] cnt;

   assign clr_o = (state == ST_IDLE) || (state == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         act_mode_o <= MODE_FAST;
         req_o      <= 1'b0;
      end else begin
         req_o <= 1'b0;
         if (!rel_i) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else begin
            case (state)
               ST_IDLE: begin
                  state      <= ST_IGNORE;
                  cnt        <= '0;
                  act_mode_o <= mode_req_i;
               end
               ST_IGNORE: begin
                  if (strobe_i) begin
                     if (cnt == CNT_LAST) begin
                        state      <= ST_WATCH;
                        cnt        <= '0;
                        act_mode_o <= mode_req_i;
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_WATCH: begin
                  if (trig_valid_i && load_en_i) begin
                     cnt        <= '0;
                     act_mode_o <= mode_req_i;
                  end else if (strobe_i) begin
                     if (!load_en_i) begin
                        cnt <= '0;
                     end else if (cnt == CNT_LAST) begin
                        if (act_mode_o != MODE_OFF) begin
                           req_o <= 1'b1;
                           state <= ST_DONE;
                        end else begin
                           cnt        <= '0;
                           act_mode_o <= mode_req_i;
                        end
                     end else begin
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               default: begin
                  state <= ST_DONE;
               end
            endcase
         end
      end
   end

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |=> !req_o);

   // R5
   req_not_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (act_mode_o != MODE_OFF));

   // R11
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && rel_i) |=> (state == ST_DONE && !req_o));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rel_i) |-> !req_o);

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
   import wdg_pkg::*;
#(
   parameter int CLKS_PER_TICK  = 4,
   parameter int SLOW_DIV       = 2,
   parameter int PERIOD_SAMPLES = 64,
   parameter int SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rel_i,
   input  logic trig_i,
   input  logic mode_b1_i,
   input  logic mode_b0_i,
   input  logic load_lo_i,
   input  logic load_hi_i,
   output logic rst_req_o
);

   wd_mode_e mode_req;
   wd_mode_e act_mode;
   logic     clr;
   logic     strobe;
   logic     trig_valid;
   logic     load_en;

   assign mode_req = decode_mode(mode_b1_i, mode_b0_i);

   wdg_timebase #(
      .CLKS_PER_TICK(CLKS_PER_TICK),
      .SLOW_DIV     (SLOW_DIV)
   ) u_timebase (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .mode_i  (act_mode),
      .strobe_o(strobe)
   );

   wdg_trig_qual #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .strobe_i(strobe),
      .trig_i  (trig_i),
      .valid_o (trig_valid)
   );

   wdg_load_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_lo_i(load_lo_i),
      .load_hi_i(load_hi_i),
      .en_o     (load_en)
   );

   wdg_seq #(
      .PERIOD_SAMPLES(PERIOD_SAMPLES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .rel_i       (rel_i),
      .strobe_i    (strobe),
      .trig_valid_i(trig_valid),
      .load_en_i   (load_en),
      .mode_req_i  (mode_req),
      .clr_o       (clr),
      .act_mode_o  (act_mode),
      .req_o       (rst_req_o)
   );

endmodule

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;

   localparam int CPT    = 4;
   localparam int DIV    = 2;
   localparam int PER    = 64;
   localparam int T_FAST = 2 * PER * CPT + 1;
   localparam int T_SLOW = 2 * PER * DIV * CPT + 1;
   localparam int T_MIX  = PER * CPT + PER * DIV * CPT + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rel = 1'b0;
   logic trig = 1'b0;
   logic mb1 = 1'b0;
   logic mb0 = 1'b0;
   logic llo = 1'b0;
   logic lhi = 1'b0;
   logic req;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wdg_supervisor #(
      .CLKS_PER_TICK (CPT),
      .SLOW_DIV      (DIV),
      .PERIOD_SAMPLES(PER),
      .SYNC_STAGES   (2)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rel_i    (rel),
      .trig_i   (trig),
      .mode_b1_i(mb1),
      .mode_b0_i(mb0),
      .load_lo_i(llo),
      .load_hi_i(lhi),
      .rst_req_o(req)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_range(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act <= lo || act > hi) begin
         errors++;
         $display("FAIL %s: actual %0d expected in (%0d,%0d]", tag, act, lo, hi);
      end
   endtask

   // edges counted from the first edge after release; -1 when none seen
   task automatic wait_req(input int limit, output int n);
      n = -1;
      for (int i = 1; i <= limit; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (req) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic restart_idle();
      @(negedge clk);
      rel  = 1'b0;
      trig = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic pulse_trig(input int hi_len, input int lo_len);
      trig = 1'b1;
      repeat (hi_len) @(negedge clk);
      trig = 1'b0;
      repeat (lo_len) @(negedge clk);
   endtask

   task automatic test_reset();
      int n;
      wait_req(300, n);
      check("R1 reset idle no request", n, -1);
   endtask

   task automatic test_fast_timeout(input logic b1, input logic b0, input string tag);
      int n;
      restart_idle();
      mb1 = b1;
      mb0 = b0;
      rel = 1'b1;
      wait_req(T_FAST + 50, n);
      check(tag, n, T_FAST);
   endtask

   task automatic test_slow_timeout();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b1;
      rel = 1'b1;
      wait_req(T_SLOW + 50, n);
      check("R3 slow request time", n, T_SLOW);
   endtask

   task automatic test_off();
      int n;
      restart_idle();
      mb1 = 1'b1;
      mb0 = 1'b1;
      rel = 1'b1;
      wait_req(3000, n);
      check("R5 off mode no request", n, -1);
   endtask

   task automatic test_deferred_mode();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      fork
         wait_req(T_SLOW + 50, n);
         begin
            repeat (100) @(negedge clk);
            mb0 = 1'b1;
         end
      join
      check("R6 mode change at boundary", n, T_MIX);
   endtask

   task automatic test_ignore_trig();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      fork
         wait_req(T_FAST + 50, n);
         begin
            repeat (40) @(negedge clk);
            pulse_trig(16, 16);
            repeat (60) @(negedge clk);
            pulse_trig(16, 16);
         end
      join
      check("R7 triggers in ignore window", n, T_FAST);
   endtask

   task automatic test_retrigger();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      fork
         wait_req(T_FAST + 300, n);
         begin
            repeat (300) @(negedge clk);
            pulse_trig(16, 16);
         end
      join
      check_range("R8 retrigger delays request", n, 560, 620);
   endtask

   task automatic test_glitch();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      fork
         wait_req(T_FAST + 50, n);
         begin
            repeat (280) @(negedge clk);
            pulse_trig(4, 20);
            pulse_trig(16, 4);
            trig = 1'b1;
         end
      join
      check("R9 single-sample glitches rejected", n, T_FAST);
      trig = 1'b0;
   endtask

   task automatic test_load();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      fork
         wait_req(1500, n);
         begin
            repeat (300) @(negedge clk);
            llo = 1'b1;
            @(negedge clk);
            llo = 1'b0;
            repeat (699) @(negedge clk);
            lhi = 1'b1;
            @(negedge clk);
            lhi = 1'b0;
         end
      join
      check_range("R10 suspend then resume with fresh period", n, 1200, 1300);
   endtask

   task automatic test_one_shot();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      wait_req(T_FAST + 50, n);
      check("R11 first request", n, T_FAST);
      checks++;
      @(posedge clk);
      @(negedge clk);
      if (req) begin
         errors++;
         $display("FAIL R11 request width: actual 1 expected 0");
      end
      wait_req(2000, n);
      check("R11 no repeat before re-release", n, -1);
      restart_idle();
      rel = 1'b1;
      wait_req(T_FAST + 50, n);
      check("R11 restart after re-release", n, T_FAST);
   endtask

   task automatic test_cancel();
      int n;
      restart_idle();
      mb1 = 1'b0;
      mb0 = 1'b0;
      rel = 1'b1;
      repeat (400) @(negedge clk);
      rel = 1'b0;
      wait_req(1000, n);
      check("R11 dropped release cancels", n, -1);
      @(negedge clk);
      rel = 1'b1;
      wait_req(T_FAST + 50, n);
      check("R11 fresh ignore window after cancel", n, T_FAST);
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_fast_timeout(1'b0, 1'b0, "R2 fast request time code 00");
      test_slow_timeout();
      test_fast_timeout(1'b1, 1'b0, "R4 fast request time code 10");
      test_off();
      test_deferred_mode();
      test_ignore_trig();
      test_retrigger();
      test_glitch();
      test_load();
      test_one_shot();
      test_cancel();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule